// File: doc/BRIEF.md
# Tagged Effective Address Modifier

This block forms the effective address of an operand for a machine with 36-bit words and 18-bit word addresses. It takes the 18-bit address field and the 6-bit tag of an instruction. It adds a value chosen by the tag: one of eight index registers, a half of the A or Q accumulator, or the instruction counter. It can also deliver the address field itself as an immediate operand. When the tag asks for indirection, the block reads indirect words through a memory port with a valid/ready handshake. Each indirect word carries a new address and a new tag, so chains of any depth are followed.

The tag has two fields. The upper two bits are the modifier, which picks plain register modification, register-then-indirect, indirect-then-register, or the indirect-special class. The lower four bits are the descriptor, which picks the value that is added. An indirect word with the segmented-pointer tag starts a two-word pointer: that word gives a segment number and the following word gives the offset and the next tag. An indirect word with the link-fault tag stops the chain with a restartable linkage fault. A counter of indirect reads ends a runaway chain with a lockup fault.

Each operation starts with a one-cycle `start_i` in idle. It ends with a one-cycle `done_o` that comes with the result: the offset, an immediate flag with its placement, a segment override, or a fault code.

Top module: `ea_modifier`

## Requirements
- R1: After reset `busy_o`, `done_o` and `mem_req_o` are 0.
- R2: The tag is split into modifier = tag[5:4] and descriptor = tag[3:0]. With modifier 00 and descriptor 1rrr, `ea_o` = address + index register rrr, modulo 2^18, with no carry out.
- R3: With modifier 00, the descriptor 0000 adds nothing. 0001 adds A[35:18] and 0010 adds Q[35:18]. 0100 adds the instruction counter. 0101 adds A[17:0] and 0110 adds Q[17:0].
- R4: With modifier 00, the descriptor 0011 gives `imm_o`=1 and `imm_hi_o`=1 (address goes in the upper half), and 0111 gives `imm_o`=1 and `imm_hi_o`=0. In both cases `ea_o` holds the address field, and no fault is raised.
- R5: Modifier 01 reads the word at address + modification. The word's bits [35:18] become the new address and bits [5:0] the new tag, and evaluation continues. Modifier 01 with descriptor 0011 or 0111 raises fault code 3 without any read.
- R6: Modifier 11 reads the word at the unmodified address and saves its descriptor. When the chain reaches a modifier-00 tag, the saved descriptor is used in place of that tag's own descriptor. A later modifier-11 tag replaces the saved descriptor.
- R7: An indirect word with tag octal 43 supplies segment number = bits [35:18]. The word at the next address then supplies the address and tag. `seg_vld_o`=1 and `seg_o` is that segment number at completion.
- R8: An indirect word with tag octal 46 ends the operation with fault code 2, and no further read is made.
- R9: Any other tag with modifier 10, whether in the instruction or in an indirect word, ends the operation with fault code 3.
- R10: At most LOCKUP_LIMIT (default 64) indirect reads are made per operation. A chain that needs exactly that many reads completes normally. A chain that needs one more read ends with fault code 1 and no further read.
- R11: `mem_req_o` and `mem_addr_o` stay unchanged until `mem_ready_i` is seen high. Read data is taken in the cycle where request and ready are both high.
- R12: `done_o` is a one-cycle pulse with exactly one pulse per accepted start. `start_i` while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| addr_i | input | 18 | Instruction address field |
| tag_i | input | 6 | Instruction tag |
| ic_i | input | 18 | Instruction counter |
| a_i | input | 36 | A accumulator |
| q_i | input | 36 | Q accumulator |
| xr_i | input | 144 | Eight index registers, register n at bits [18n+17:18n] |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Result valid for one cycle |
| ea_o | output | 18 | Effective offset, or immediate field |
| imm_o | output | 1 | Result is an immediate operand |
| imm_hi_o | output | 1 | Immediate goes in the upper half |
| seg_vld_o | output | 1 | Segment override present |
| seg_o | output | 18 | Segment number from a two-word pointer |
| fault_o | output | 1 | Operation ended in a fault |
| fault_code_o | output | 2 | 1 lockup, 2 linkage, 3 illegal modifier |
| mem_req_o | output | 1 | Indirect read request (valid) |
| mem_addr_o | output | 18 | Indirect read address |
| mem_ready_i | input | 1 | Memory accepts the request and returns data |
| mem_rdata_i | input | 36 | Indirect word |

## Verification
The bench aims at index addition that wraps past 2^18 and at each direct descriptor code. A wrong slice or code mapping would add the wrong half of an accumulator. It runs indirect-then-register chains whose final word names a different register. A design that ignored the saved descriptor would add the word's own register. It also checks that a later indirect-then-register tag overrides the saved one. The bench probes the lockup boundary from both sides: one chain needs exactly the limit of reads and one never ends. An off-by-one counter would fault the first chain or make an extra read on the second. The two-word pointer, the link-fault and illegal tags, a stray start during a long chain, and random memory stalls show whether the design reads past a fault, drops a request, or emits a second done.

// File: rtl/ea_modifier_pkg.sv
package ea_modifier_pkg;
  localparam int unsigned NUM_XR = 8;
  localparam int unsigned TAG_W  = 6;

  typedef enum logic [1:0] {
    MOD_R  = 2'b00,
    MOD_RI = 2'b01,
    MOD_IT = 2'b10,
    MOD_IR = 2'b11
  } mod_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_LOCKUP  = 2'd1,
    FLT_LINK    = 2'd2,
    FLT_ILLEGAL = 2'd3
  } flt_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_EVAL, ST_FETCH, ST_FETCH2
  } st_e;

  localparam logic [TAG_W-1:0] TAG_SEGPTR  = 6'o43;
  localparam logic [TAG_W-1:0] TAG_LINKFLT = 6'o46;
endpackage

// File: rtl/eam_index_sel.sv
module eam_index_sel
  import ea_modifier_pkg::*;
#(
  parameter int unsigned AW = 18,
  parameter int unsigned DW = 36
) (
  input  logic [3:0]           td_i,
  input  logic [NUM_XR*AW-1:0] xr_i,
  input  logic [DW-1:0]        a_i,
  input  logic [DW-1:0]        q_i,
  input  logic [AW-1:0]        ic_i,
  output logic [AW-1:0]        idx_o,
  output logic                 imm_o,
  output logic                 imm_hi_o
);
  logic [AW-1:0] xr [NUM_XR];

  for (genvar g = 0; g < NUM_XR; g++) begin : g_xr
    assign xr[g] = xr_i[g*AW +: AW];
  end

  always_comb begin
    idx_o    = '0;
    imm_o    = 1'b0;
    imm_hi_o = 1'b0;
    if (td_i[3]) begin
      idx_o = xr[td_i[2:0]];
    end else begin
      unique case (td_i[2:0])
        3'd0: idx_o = '0;
        3'd1: idx_o = a_i[DW-1 -: AW];
        3'd2: idx_o = q_i[DW-1 -: AW];
        3'd3: begin imm_o = 1'b1; imm_hi_o = 1'b1; end
        3'd4: idx_o = ic_i;
        3'd5: idx_o = a_i[AW-1:0];
        3'd6: idx_o = q_i[AW-1:0];
        3'd7: imm_o = 1'b1;
        default: idx_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/eam_lockup.sv
module eam_lockup #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_limit_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (inc_i && !at_limit_o) cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit_o = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/ea_modifier.sv
module ea_modifier
  import ea_modifier_pkg::*;
#(
  parameter int unsigned AW           = 18,
  parameter int unsigned DW           = 36,
  parameter int unsigned LOCKUP_LIMIT = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [TAG_W-1:0]     tag_i,
  input  logic [AW-1:0]        ic_i,
  input  logic [DW-1:0]        a_i,
  input  logic [DW-1:0]        q_i,
  input  logic [NUM_XR*AW-1:0] xr_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [AW-1:0]        ea_o,
  output logic                 imm_o,
  output logic                 imm_hi_o,
  output logic                 seg_vld_o,
  output logic [AW-1:0]        seg_o,
  output logic                 fault_o,
  output logic [1:0]           fault_code_o,
  output logic                 mem_req_o,
  output logic [AW-1:0]        mem_addr_o,
  input  logic                 mem_ready_i,
  input  logic [DW-1:0]        mem_rdata_i
);
  st_e              st_q, st_d;
  logic [AW-1:0]    cur_y_q, rd_addr_q, seg_q, ea_q;
  logic [TAG_W-1:0] cur_tag_q;
  logic             pend_vld_q, seg_vld_q, done_q, imm_q, hi_q;
  logic [3:0]       pend_td_q;
  flt_e             flt_q;

  mod_e          cur_mod;
  logic [3:0]    td_sel;
  logic [AW-1:0] idx, sum, w_addr, iss_addr, f_ea;
  logic [TAG_W-1:0] w_tag;
  logic          sel_imm, sel_hi, at_limit, accept;
  logic          fin, f_imm, f_hi, issue, ld_word, set_pend, set_seg;
  flt_e          f_flt;
  logic          unused_rdata;

  assign cur_mod = mod_e'(cur_tag_q[5:4]);
  assign td_sel  = (cur_mod == MOD_R && pend_vld_q) ? pend_td_q : cur_tag_q[3:0];
  assign w_addr  = mem_rdata_i[DW-1 -: AW];
  assign w_tag   = mem_rdata_i[TAG_W-1:0];
  assign unused_rdata = ^mem_rdata_i[DW-AW-1:TAG_W];
  assign sum     = cur_y_q + idx;
  assign accept  = (st_q == ST_IDLE) && start_i;

  eam_index_sel #(.AW(AW), .DW(DW)) u_idx (
    .td_i    (td_sel),
    .xr_i    (xr_i),
    .a_i     (a_i),
    .q_i     (q_i),
    .ic_i    (ic_i),
    .idx_o   (idx),
    .imm_o   (sel_imm),
    .imm_hi_o(sel_hi)
  );

  eam_lockup #(.LIMIT(LOCKUP_LIMIT)) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept),
    .inc_i     (issue),
    .at_limit_o(at_limit)
  );

  always_comb begin
    st_d     = st_q;
    fin      = 1'b0;
    f_flt    = FLT_NONE;
    f_imm    = 1'b0;
    f_hi     = 1'b0;
    f_ea     = sum;
    issue    = 1'b0;
    iss_addr = rd_addr_q;
    ld_word  = 1'b0;
    set_pend = 1'b0;
    set_seg  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_EVAL;
      ST_EVAL: begin
        unique case (cur_mod)
          MOD_R: begin
            fin   = 1'b1;
            f_imm = sel_imm;
            f_hi  = sel_hi;
            if (sel_imm) f_ea = cur_y_q;
          end
          MOD_RI: begin
            if (sel_imm)       begin fin = 1'b1; f_flt = FLT_ILLEGAL; end
            else if (at_limit) begin fin = 1'b1; f_flt = FLT_LOCKUP;  end
            else begin issue = 1'b1; iss_addr = sum; st_d = ST_FETCH; end
          end
          MOD_IR: begin
            set_pend = 1'b1;
            if (at_limit) begin fin = 1'b1; f_flt = FLT_LOCKUP; end
            else begin issue = 1'b1; iss_addr = cur_y_q; st_d = ST_FETCH; end
          end
          default: begin fin = 1'b1; f_flt = FLT_ILLEGAL; end
        endcase
      end
      ST_FETCH: begin
        if (mem_ready_i) begin
          if (w_tag == TAG_SEGPTR) begin
            set_seg = 1'b1;
            if (at_limit) begin fin = 1'b1; f_flt = FLT_LOCKUP; end
            else begin issue = 1'b1; iss_addr = rd_addr_q + 1'b1; st_d = ST_FETCH2; end
          end else if (w_tag == TAG_LINKFLT) begin
            fin = 1'b1; f_flt = FLT_LINK;
          end else if (w_tag[5:4] == MOD_IT) begin
            fin = 1'b1; f_flt = FLT_ILLEGAL;
          end else begin
            ld_word = 1'b1; st_d = ST_EVAL;
          end
        end
      end
      ST_FETCH2: if (mem_ready_i) begin ld_word = 1'b1; st_d = ST_EVAL; end
      default: st_d = ST_IDLE;
    endcase
    if (fin) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cur_y_q    <= '0;
      cur_tag_q  <= '0;
      rd_addr_q  <= '0;
      pend_vld_q <= 1'b0;
      pend_td_q  <= '0;
      seg_q      <= '0;
      seg_vld_q  <= 1'b0;
      done_q     <= 1'b0;
      ea_q       <= '0;
      imm_q      <= 1'b0;
      hi_q       <= 1'b0;
      flt_q      <= FLT_NONE;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      if (accept) begin
        cur_y_q    <= addr_i;
        cur_tag_q  <= tag_i;
        pend_vld_q <= 1'b0;
        seg_vld_q  <= 1'b0;
      end
      if (ld_word) begin
        cur_y_q   <= w_addr;
        cur_tag_q <= w_tag;
      end
      if (set_pend) begin
        pend_vld_q <= 1'b1;
        pend_td_q  <= cur_tag_q[3:0];
      end
      if (set_seg) begin
        seg_vld_q <= 1'b1;
        seg_q     <= w_addr;
      end
      if (issue) rd_addr_q <= iss_addr;
      if (fin) begin
        ea_q  <= f_ea;
        imm_q <= f_imm;
        hi_q  <= f_hi;
        flt_q <= f_flt;
      end
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = done_q;
  assign ea_o         = ea_q;
  assign imm_o        = done_q && imm_q;
  assign imm_hi_o     = done_q && hi_q;
  assign seg_vld_o    = done_q && seg_vld_q;
  assign seg_o        = seg_q;
  assign fault_o      = done_q && (flt_q != FLT_NONE);
  assign fault_code_o = done_q ? flt_q : FLT_NONE;
  assign mem_req_o    = (st_q == ST_FETCH) || (st_q == ST_FETCH2);
  assign mem_addr_o   = rd_addr_q;
endmodule

// File: rtl/ea_modifier_chk.sv
module ea_modifier_chk #(
  parameter int unsigned AW    = 18,
  parameter int unsigned LIMIT = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          imm_o,
  input logic          fault_o,
  input logic          seg_vld_o,
  input logic          mem_req_o,
  input logic          mem_ready_i,
  input logic [AW-1:0] mem_addr_o
);
  int unsigned rd_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     rd_cnt <= 0;
    else if (start_i && !busy_o)     rd_cnt <= 0;
    else if (mem_req_o && mem_ready_i) rd_cnt <= rd_cnt + 1;
  end

  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));

  p_read_cap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cnt <= LIMIT);

  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_start_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && !done_o);

  p_imm_no_fault_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(imm_o && fault_o));

  p_seg_two_reads_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_vld_o |-> rd_cnt >= 2);

  p_done_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !mem_req_o);
endmodule

bind ea_modifier ea_modifier_chk #(.AW(AW), .LIMIT(LOCKUP_LIMIT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .imm_o      (imm_o),
  .fault_o    (fault_o),
  .seg_vld_o  (seg_vld_o),
  .mem_req_o  (mem_req_o),
  .mem_ready_i(mem_ready_i),
  .mem_addr_o (mem_addr_o)
);

// File: tb/ea_modifier_tb.sv
module ea_modifier_tb;
  localparam int AW = 18;
  localparam int DW = 36;
  localparam int LIM = 64;

  typedef struct {
    string       req;
    logic [17:0] ea;
    bit          imm;
    bit          hi;
    bit          segv;
    logic [17:0] seg;
    logic [1:0]  flt;
    int          reads;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [17:0] addr = 0, ic = 0;
  logic [5:0] tag = 0;
  logic [35:0] a = 0, q = 0;
  logic [17:0] xr [8];
  logic [8*18-1:0] xr_flat;
  logic busy, done, imm, imm_hi, segv, flt, mreq, mrdy = 0;
  logic [17:0] ea, seg, maddr;
  logic [1:0] fcode;
  logic [35:0] mrdata = 0;
  logic [35:0] mem [1024];

  int checks = 0, fails = 0, rd_cnt = 0, hs_bad = 0;
  bit prev_pend = 0, timeout = 0;
  logic [17:0] prev_addr = 0;
  exp_t sb [$];

  always #5 clk = ~clk;

  for (genvar g = 0; g < 8; g++) begin : g_xr
    assign xr_flat[g*18 +: 18] = xr[g];
  end

  ea_modifier #(.AW(AW), .DW(DW), .LOCKUP_LIMIT(LIM)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .tag_i(tag),
    .ic_i(ic), .a_i(a), .q_i(q), .xr_i(xr_flat), .busy_o(busy), .done_o(done),
    .ea_o(ea), .imm_o(imm), .imm_hi_o(imm_hi), .seg_vld_o(segv), .seg_o(seg),
    .fault_o(flt), .fault_code_o(fcode), .mem_req_o(mreq), .mem_addr_o(maddr),
    .mem_ready_i(mrdy), .mem_rdata_i(mrdata)
  );

  function automatic logic [35:0] mkw(input logic [17:0] ad, input logic [5:0] t);
    return {ad, 12'b0, t};
  endfunction

  // memory model: random stalls, checks request hold
  always @(negedge clk) begin
    if (prev_pend && !(mreq && maddr == prev_addr)) hs_bad++;
    mrdy   = mreq && ($urandom_range(0, 2) != 0);
    mrdata = mem[maddr[9:0]];
  end

  always @(posedge clk) begin
    prev_pend <= mreq && !mrdy;
    prev_addr <= maddr;
    if (mreq && mrdy) rd_cnt <= rd_cnt + 1;
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R12: extra done, actual=1 expected=0");
      end else begin
        exp_t e;
        bit bad;
        e = sb.pop_front();
        bad = (fcode !== e.flt) || (rd_cnt != e.reads);
        if (e.flt == 0)
          bad = bad || (ea !== e.ea) || (imm !== e.imm) || (imm_hi !== e.hi) ||
                (segv !== e.segv) || (e.segv && seg !== e.seg);
        if (bad) begin
          fails++;
          $display("FAIL %s: actual ea=%h imm=%b hi=%b segv=%b seg=%h flt=%0d reads=%0d expected ea=%h imm=%b hi=%b segv=%b seg=%h flt=%0d reads=%0d",
                   e.req, ea, imm, imm_hi, segv, seg, fcode, rd_cnt,
                   e.ea, e.imm, e.hi, e.segv, e.seg, e.flt, e.reads);
        end
      end
    end
  end

  task automatic run_op(input string r, input logic [17:0] y, input logic [5:0] t,
                        input logic [17:0] xea, input bit ximm, input bit xhi,
                        input bit xsegv, input logic [17:0] xseg,
                        input logic [1:0] xflt, input int xreads, input bit stray = 0);
    exp_t e;
    e.req = r; e.ea = xea; e.imm = ximm; e.hi = xhi; e.segv = xsegv;
    e.seg = xseg; e.flt = xflt; e.reads = xreads;
    sb.push_back(e);
    @(negedge clk);
    rd_cnt = 0;
    addr = y; tag = t; start = 1;
    @(negedge clk);
    start = 0;
    if (stray) begin
      repeat (5) @(negedge clk);
      addr = 18'h00001; tag = 6'o00; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int g = 0; g < 8; g++) xr[g] = 18'(16 * g + 5);
    xr[3] = 18'h00020;
    a  = 36'h9ABCD1234;
    q  = 36'h3579BDEF0;
    ic = 18'h01234;
    mem[121] = mkw(18'd200, 6'o00);
    mem[300] = mkw(18'd400, 6'b00_1001);
    mem[310] = mkw(18'd320, 6'b11_1100);
    mem[320] = mkw(18'd500, 6'b00_0000);
    mem[330] = mkw(18'd77,  6'b00_0000);
    mem[600] = mkw(18'o1234, 6'o43);
    mem[601] = mkw(18'd700, 6'b00_1001);
    mem[610] = mkw(18'd1, 6'o46);
    mem[620] = mkw(18'd1, 6'o50);
    mem[800] = mkw(18'd800, 6'b01_0000);
    for (int i = 0; i < 63; i++) mem[900 + i] = mkw(18'(901 + i), 6'b01_0000);
    mem[963] = mkw(18'd42, 6'b00_0000);

    repeat (3) @(negedge clk);
    checks++;
    if (busy !== 0 || done !== 0 || mreq !== 0) begin
      fails++;
      $display("FAIL R1: actual busy=%b done=%b req=%b expected 0 0 0", busy, done, mreq);
    end
    rst_n = 1;

    // R2: index register, wrap
    run_op("R2", 18'h3FFF0, 6'b00_1011, 18'h00010, 0, 0, 0, 0, 0, 0);
    run_op("R2", 18'd1000, 6'b00_1000, 18'(1000 + xr[0]), 0, 0, 0, 0, 0, 0);
    // R3: direct codes
    run_op("R3", 18'd10, 6'b00_0000, 18'd10, 0, 0, 0, 0, 0, 0);
    run_op("R3", 18'd10, 6'b00_0001, 18'(18'd10 + a[35:18]), 0, 0, 0, 0, 0, 0);
    run_op("R3", 18'd10, 6'b00_0010, 18'(18'd10 + q[35:18]), 0, 0, 0, 0, 0, 0);
    run_op("R3", 18'd10, 6'b00_0100, 18'(18'd10 + ic), 0, 0, 0, 0, 0, 0);
    run_op("R3", 18'd10, 6'b00_0101, 18'(18'd10 + a[17:0]), 0, 0, 0, 0, 0, 0);
    run_op("R3", 18'd10, 6'b00_0110, 18'(18'd10 + q[17:0]), 0, 0, 0, 0, 0, 0);
    // R4: immediates
    run_op("R4", 18'h2A5A5, 6'b00_0011, 18'h2A5A5, 1, 1, 0, 0, 0, 0);
    run_op("R4", 18'h15A5A, 6'b00_0111, 18'h15A5A, 1, 0, 0, 0, 0, 0);
    // R5: register then indirect
    run_op("R5", 18'd100, 6'b01_1001, 18'd200, 0, 0, 0, 0, 0, 1);
    run_op("R5", 18'd5, 6'b01_0011, 0, 0, 0, 0, 0, 3, 0);
    // R6: indirect then register
    run_op("R6", 18'd300, 6'b11_1010, 18'(400 + xr[2]), 0, 0, 0, 0, 0, 1);
    run_op("R6", 18'd310, 6'b11_1010, 18'(500 + xr[4]), 0, 0, 0, 0, 0, 2);
    run_op("R6", 18'd330, 6'b11_0011, 18'd77, 1, 1, 0, 0, 0, 1);
    // R7: two-word pointer
    run_op("R7", 18'd600, 6'b01_0000, 18'(700 + xr[1]), 0, 0, 1, 18'o1234, 0, 2);
    // R8: link fault
    run_op("R8", 18'd610, 6'b01_0000, 0, 0, 0, 0, 0, 2, 1);
    // R9: illegal in instruction and in word
    run_op("R9", 18'd5, 6'o43, 0, 0, 0, 0, 0, 3, 0);
    run_op("R9", 18'd620, 6'b01_0000, 0, 0, 0, 0, 0, 3, 1);
    // R10: exactly limit succeeds; runaway chain faults (stray start for R12)
    run_op("R10", 18'd900, 6'b01_0000, 18'd42, 0, 0, 0, 0, 0, LIM);
    run_op("R10", 18'd800, 6'b01_0000, 0, 0, 0, 0, 0, 1, LIM, 1);

    repeat (5) @(negedge clk);
    checks++;
    if (hs_bad != 0) begin
      fails++;
      $display("FAIL R11: actual handshake violations=%0d expected=0", hs_bad);
    end
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R12: actual pending results=%0d expected=0", sb.size());
    end
    if (!timeout) begin
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    timeout = 1;
    checks++;
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule